// File: doc/BRIEF.md
# Exception Vector Catch Unit

This block watches the instruction fetches that the core commits and signals a debug event when one of them reads an exception vector that debug software has chosen to trap. A control register holds one enable per exception kind. Coprocessor move instructions write it through a simple write port and read it back through a read port.

Writes are not applied at once. A written value waits in a staging register and becomes active only at the next instruction barrier strobe. Each enabled exception matches its vector in either the low or the high vector table, selected by an input. The IRQ vector is an exception: it is compared against an address supplied at run time, because the interrupt vector can be relocated.

A two-bit debug mode input decides what a catch does. It can do nothing, request entry into debug state, or raise a debug exception. The committed-fetch stream is a valid strobe with an address and has no back-pressure. The block accepts one fetch every cycle and answers each accepted fetch with at most one single-cycle pulse, one clock later.

Top module: `vcatch_unit`

## Requirements
- R1: After reset the register reads 0 and neither event output is asserted.
- R2: A register write without a barrier changes neither the read value nor which fetches are caught.
- R3: A barrier with no write in the same cycle applies the most recent staged write. A later staged write replaces an earlier one. A barrier with nothing staged leaves the register unchanged.
- R4: A write and a barrier in the same cycle make the written value effective from the next clock edge.
- R5: Only bits 0,1,2,3,4,6,7 are stored. Bit 5 and bits 31:8 always read 0, whatever was written to them.
- R6: With the high-vector select at 0, enables 0,1,2,3,4,7 catch fetches of 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x1C respectively.
- R7: With the high-vector select at 1, the same enables catch 0xFFFF0000 plus the same offsets, and no longer catch the low addresses.
- R8: Enable bit 6 catches a fetch whose address equals the IRQ vector address input, whatever value that input holds.
- R9: The debug mode decides the result of a catch. 00 gives no event, 01 and 11 give a debug-state-entry pulse, and 10 gives a debug-exception pulse. The pulse lasts one cycle and appears in the cycle after the fetch strobe.
- R10: No event results from a cycle without a fetch strobe, from a fetch of a vector whose enable is 0, or from a fetch of any address that is not a vector.
- R11: The two event outputs are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write value |
| cfg_rd_data | output | 32 | Effective register value |
| barrier | input | 1 | Instruction barrier strobe; applies the staged write |
| hivec_sel | input | 1 | 1 selects the high vector table |
| irq_vec_addr | input | 32 | Current IRQ vector address |
| fetch_valid | input | 1 | A committed fetch is presented this cycle |
| fetch_addr | input | 32 | Address of the committed fetch |
| dbg_mode | input | 2 | Catch action: 00 none, 01/11 state entry, 10 exception |
| evt_dbg_exc | output | 1 | Debug exception pulse |
| evt_dbg_entry | output | 1 | Debug state entry pulse |

## Verification
The hardest case to reach is the gap between a staged write and the barrier that applies it. During that gap the read port and the catch logic must still behave as the old enables dictate, even though a different value is waiting. The stimulus reaches it in steps. It first applies a known value with a combined write and barrier. It then stages other values without a barrier, fetches a vector that only the staged value would catch, and reads back. Finally it issues a bare barrier and checks that the latest staged value, and not an earlier one, took effect.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
  // number of catch lanes in the control register
  localparam int unsigned NVEC    = 8;
  // lane whose vector address is supplied at run time
  localparam int unsigned IRQ_IDX = 6;
  // lane that is reserved and never matches
  localparam int unsigned RSV_IDX = 5;
  // byte spacing between consecutive vectors
  localparam int unsigned VSTEP   = 4;

  typedef enum logic [1:0] {
    DM_OFF   = 2'b00,
    DM_HALT  = 2'b01,
    DM_EXC   = 2'b10,
    DM_HALT2 = 2'b11
  } dbg_mode_e;
endpackage

// File: rtl/vcatch_regs.sv
module vcatch_regs #(
  parameter int unsigned        REG_W      = 32,
  parameter logic [REG_W-1:0]   VALID_MASK = 32'h0000_00DF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             barrier,
  output logic [REG_W-1:0] eff
);
  logic [REG_W-1:0] pend_q;
  logic             pend_v;
  logic [REG_W-1:0] wr_masked;

  assign wr_masked = wr_data & VALID_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pend_v <= 1'b0;
      eff    <= '0;
    end else if (barrier) begin
      pend_v <= 1'b0;
      if (wr_en)       eff <= wr_masked;  // same-cycle write wins
      else if (pend_v) eff <= pend_q;
    end else if (wr_en) begin
      pend_q <= wr_masked;
      pend_v <= 1'b1;
    end
  end
endmodule

// File: rtl/vcatch_match.sv
module vcatch_match #(
  parameter int unsigned          ADDR_W  = 32,
  parameter logic [ADDR_W-1:0]    HI_BASE = 32'hFFFF_0000
) (
  input  logic [vcatch_pkg::NVEC-1:0] en,
  input  logic                        hivec_sel,
  input  logic [ADDR_W-1:0]           irq_addr,
  input  logic [ADDR_W-1:0]           addr,
  output logic                        hit
);
  import vcatch_pkg::*;

  localparam logic RSV_CATCH = 1'b0;

  logic [ADDR_W-1:0] vbase;
  logic [NVEC-1:0]   lane_hit;

  assign vbase = hivec_sel ? HI_BASE : '0;

  for (genvar i = 0; i < NVEC; i++) begin : g_lane
    if (i == RSV_IDX) begin : g_rsv
      assign lane_hit[i] = en[i] & RSV_CATCH;
    end else if (i == IRQ_IDX) begin : g_irq
      assign lane_hit[i] = en[i] && (addr == irq_addr);
    end else begin : g_fix
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * VSTEP);
      assign lane_hit[i] = en[i] && (addr == (vbase + OFS));
    end
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/vcatch_event.sv
module vcatch_event (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       hit,
  input  logic [1:0] mode,
  output logic       exc,
  output logic       entry
);
  import vcatch_pkg::*;

  dbg_mode_e dm;
  logic      catch_now;

  assign dm        = dbg_mode_e'(mode);
  assign catch_now = valid && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc   <= 1'b0;
      entry <= 1'b0;
    end else begin
      exc   <= catch_now && (dm == DM_EXC);
      entry <= catch_now && ((dm == DM_HALT) || (dm == DM_HALT2));
    end
  end
endmodule

// File: rtl/vcatch_unit.sv
module vcatch_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              barrier,
  input  logic              hivec_sel,
  input  logic [ADDR_W-1:0] irq_vec_addr,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        dbg_mode,
  output logic              evt_dbg_exc,
  output logic              evt_dbg_entry
);
  import vcatch_pkg::*;

  localparam logic [REG_W-1:0]  MASK    = REG_W'(32'h0000_00DF);
  localparam logic [ADDR_W-1:0] HI_BASE = {{(ADDR_W-16){1'b1}}, 16'h0000};

  logic [REG_W-1:0] eff;
  logic             hit;

  vcatch_regs #(.REG_W(REG_W), .VALID_MASK(MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .barrier (barrier),
    .eff     (eff)
  );

  vcatch_match #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_match (
    .en        (eff[NVEC-1:0]),
    .hivec_sel (hivec_sel),
    .irq_addr  (irq_vec_addr),
    .addr      (fetch_addr),
    .hit       (hit)
  );

  vcatch_event u_event (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (fetch_valid),
    .hit   (hit),
    .mode  (dbg_mode),
    .exc   (evt_dbg_exc),
    .entry (evt_dbg_entry)
  );

  assign cfg_rd_data = eff;
endmodule

// File: rtl/vcatch_checker.sv
module vcatch_checker #(
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             barrier,
  input logic             fetch_valid,
  input logic [1:0]       dbg_mode,
  input logic             evt_dbg_exc,
  input logic             evt_dbg_entry
);
  localparam logic [REG_W-1:0] MASK = REG_W'(32'h0000_00DF);

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_dbg_exc, evt_dbg_entry}));

  assert_rsv_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~MASK) == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !barrier |=> $stable(cfg_rd_data));

  assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier && cfg_wr_en) |=> cfg_rd_data == ($past(cfg_wr_data) & MASK));

  assert_need_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_dbg_exc || evt_dbg_entry) |-> $past(fetch_valid));

  assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && dbg_mode == 2'b00) |=> !(evt_dbg_exc || evt_dbg_entry));
endmodule

bind vcatch_unit vcatch_checker #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_wr_data   (cfg_wr_data),
  .cfg_rd_data   (cfg_rd_data),
  .barrier       (barrier),
  .fetch_valid   (fetch_valid),
  .dbg_mode      (dbg_mode),
  .evt_dbg_exc   (evt_dbg_exc),
  .evt_dbg_entry (evt_dbg_entry)
);

// File: tb/test_vcatch_unit.sv
`timescale 1ns/1ps
module test_vcatch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        barrier = 1'b0;
  logic        hivec_sel = 1'b0;
  logic [31:0] irq_vec_addr = 32'h18;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [1:0]  dbg_mode = 2'b00;
  logic        evt_dbg_exc;
  logic        evt_dbg_entry;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  vcatch_unit i_vcatch_unit (.*);

  typedef struct packed {
    logic [7:0]  en;
    logic        hv;
    logic [31:0] irq;
    logic [1:0]  mode;
    logic [31:0] addr;
    logic        exc;
    logic        ent;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b0, 32'h18,       2'b01, 32'h0000_0000, 1'b0, 1'b1}, // R6 reset lane
    '{8'h02, 1'b0, 32'h18,       2'b10, 32'h0000_0004, 1'b1, 1'b0}, // R6 R9 exception
    '{8'h04, 1'b1, 32'hFFFF0018, 2'b01, 32'hFFFF_0008, 1'b0, 1'b1}, // R7
    '{8'h08, 1'b1, 32'hFFFF0018, 2'b11, 32'hFFFF_000C, 1'b0, 1'b1}, // R7 R9 mode 11
    '{8'h10, 1'b0, 32'h18,       2'b10, 32'h0000_0010, 1'b1, 1'b0}, // R6
    '{8'h80, 1'b1, 32'hFFFF0018, 2'b01, 32'hFFFF_001C, 1'b0, 1'b1}, // R7 FIQ
    '{8'h40, 1'b0, 32'h0000_1000,2'b10, 32'h0000_1000, 1'b1, 1'b0}, // R8 moved IRQ
    '{8'h40, 1'b0, 32'h0000_1000,2'b10, 32'h0000_0018, 1'b0, 1'b0}, // R8 old IRQ slot
    '{8'hDF, 1'b0, 32'h18,       2'b00, 32'h0000_0000, 1'b0, 1'b0}, // R9 mode off
    '{8'hDF, 1'b1, 32'hFFFF0018, 2'b01, 32'h0000_0000, 1'b0, 1'b0}, // R7 low addr ignored
    '{8'hFE, 1'b0, 32'h18,       2'b01, 32'h0000_0000, 1'b0, 1'b0}, // R10 lane disabled
    '{8'hFF, 1'b0, 32'h18,       2'b01, 32'h0000_0014, 1'b0, 1'b0}  // R10 non-vector
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [31:0] d, input logic b);
    cfg_wr_en = 1'b1; cfg_wr_data = d; barrier = b;
    @(negedge clk);
    cfg_wr_en = 1'b0; barrier = 1'b0;
  endtask

  task automatic bar_only();
    barrier = 1'b1;
    @(negedge clk);
    barrier = 1'b0;
  endtask

  // one-cycle fetch; returns after the registered response is visible
  task automatic fetch(input logic [31:0] a, input logic [1:0] m);
    fetch_valid = 1'b1; fetch_addr = a; dbg_mode = m;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_rd_data == 32'h0, "R1 read after reset", cfg_rd_data, 32'h0);
    check({evt_dbg_exc, evt_dbg_entry} == 2'b00, "R1 events after reset",
          {30'h0, evt_dbg_exc, evt_dbg_entry}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int k = 0; k < NV; k++) begin
      hivec_sel = VECS[k].hv;
      irq_vec_addr = VECS[k].irq;
      cfg({24'h0, VECS[k].en}, 1'b1);
      fetch(VECS[k].addr, VECS[k].mode);
      check(evt_dbg_exc == VECS[k].exc && evt_dbg_entry == VECS[k].ent,
            $sformatf("R6/R7/R8/R9/R10 table row %0d", k),
            {30'h0, evt_dbg_exc, evt_dbg_entry}, {30'h0, VECS[k].exc, VECS[k].ent});
      @(negedge clk);
      check({evt_dbg_exc, evt_dbg_entry} == 2'b00, "R9 pulse one cycle",
            {30'h0, evt_dbg_exc, evt_dbg_entry}, 32'h0);
    end

    hivec_sel = 1'b0; irq_vec_addr = 32'h18;

    // R4 combined write and barrier
    cfg(32'h0000_0000, 1'b1);
    check(cfg_rd_data == 32'h0, "R4 immediate apply", cfg_rd_data, 32'h0);

    // R2 staged write without barrier
    cfg(32'h0000_0001, 1'b0);
    check(cfg_rd_data == 32'h0, "R2 read unchanged", cfg_rd_data, 32'h0);
    fetch(32'h0, 2'b01);
    check(evt_dbg_entry == 1'b0, "R2 no catch before barrier",
          {31'h0, evt_dbg_entry}, 32'h0);

    // R3 later staged write replaces earlier
    cfg(32'h0000_0002, 1'b0);
    bar_only();
    check(cfg_rd_data == 32'h2, "R3 latest staged applied", cfg_rd_data, 32'h2);
    fetch(32'h4, 2'b01);
    check(evt_dbg_entry == 1'b1, "R3 catch after barrier",
          {31'h0, evt_dbg_entry}, 32'h1);
    bar_only();
    check(cfg_rd_data == 32'h2, "R3 empty barrier keeps value", cfg_rd_data, 32'h2);

    // R4 same-cycle write beats staged value
    cfg(32'h0000_0010, 1'b0);
    cfg(32'h0000_0080, 1'b1);
    check(cfg_rd_data == 32'h80, "R4 same-cycle write wins", cfg_rd_data, 32'h80);

    // R5 reserved bits
    cfg(32'hFFFF_FFFF, 1'b1);
    check(cfg_rd_data == 32'hDF, "R5 reserved read zero", cfg_rd_data, 32'hDF);

    // R10 no strobe
    fetch_addr = 32'h0; dbg_mode = 2'b01;
    @(negedge clk);
    check({evt_dbg_exc, evt_dbg_entry} == 2'b00, "R10 no strobe no event",
          {30'h0, evt_dbg_exc, evt_dbg_entry}, 32'h0);

    // R9 R11 back-to-back fetches, switching mode
    fetch_valid = 1'b1; fetch_addr = 32'h8; dbg_mode = 2'b10;
    @(negedge clk);
    check(evt_dbg_exc == 1'b1 && evt_dbg_entry == 1'b0, "R11 exception only",
          {30'h0, evt_dbg_exc, evt_dbg_entry}, 32'h2);
    fetch_addr = 32'h1C; dbg_mode = 2'b11;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(evt_dbg_exc == 1'b0 && evt_dbg_entry == 1'b1, "R9 entry back-to-back",
          {30'h0, evt_dbg_exc, evt_dbg_entry}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule